// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Shifter

This block is a clock-synchronous serial master that moves bytes in both directions through a single shift register. A transmit holding register and a receive holding register sit on either side of the shifter. Software reaches both through a one-cycle register port. A write-enable, a read-enable and a one-bit address select between the two: address 0 is the transmit register and address 1 is the receive register.

Once the shifter is idle and the transmit holding register holds a byte, that byte moves into the shifter and eight bits go out on `sdo`. At the same time eight bits come in from `sdi`. The block makes its own serial clock `sck` from the system clock through a programmable divider. `sck` idles high. Data changes on each falling edge and is sampled on each rising edge. If software refills the transmit register before the current byte ends, the next byte follows with no gap in `sck`.

The byte order is selectable. Status outputs report an empty transmit register, a full receive register, transmission end and overrun.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset both data registers read 0xFF, `tx_empty`=1, `rx_full`=0, `overrun`=0, `tx_end`=1, `sck`=1 and `sdo`=1.
- R2: A write to address 0 clears `tx_empty`. On the next clock edge, if the shifter is idle, the byte moves into the shifter, `sck` falls, `tx_empty` is set again and `tx_end` clears.
- R3: If the transmit register is refilled before the running byte ends, the next byte starts on the edge that ends the current one. A two-byte burst then holds `tx_end` low for exactly 32*(`half_div`+1) cycles.
- R4: Each `sck` half-period lasts `half_div`+1 system cycles, and one byte is 16 half-periods. Within a byte, `sdo` changes only when `sck` falls, and `sdi` is sampled when `sck` rises. While idle, `sck` and `sdo` are high.
- R5: With `lsb_first`=0, bit 7 of the written byte goes out first. With `lsb_first`=1, the written byte is stored bit-reversed, a read at address 0 returns the reversed value, and bit 0 goes out first. A received byte is assembled in the matching order: with `lsb_first`=1 the first bit received lands in bit 0.
- R6: When a byte completes while `rx_full`=0 and `overrun`=0, that byte goes to the receive register and `rx_full` is set. A read with `rd_en`=1 at address 1 clears `rx_full`.
- R7: When a byte completes while `rx_full`=1, `overrun` is set and the receive register keeps its earlier byte. While `overrun`=1, completed bytes are discarded. A write to address 1 clears `overrun` and never changes the receive register.
- R8: `tx_end` rises when a byte completes with the transmit register empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (its side effect is clearing `rx_full`) |
| addr | input | 1 | 0 selects the transmit register, 1 selects the receive register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the selected register |
| lsb_first | input | 1 | 1 selects least-significant-bit-first order |
| half_div | input | DIVW | `sck` half-period minus one, in system cycles |
| sck | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_empty | output | 1 | Transmit register may be written |
| rx_full | output | 1 | Receive register holds an unread byte |
| overrun | output | 1 | A byte was lost because the receive register was full |
| tx_end | output | 1 | Shifter idle with nothing queued |

## Verification
On every cycle, the assertions check that `sck` only moves on a divider tick or a load, and that the lines idle high. They also check how the flags react to a completed byte, and that the receive register holds still through overrun and through writes to address 1. The exact `sck`/`sdo` waveform, the values of received bytes in each bit order, the reversed read-back and the gap-free burst length can only be shown by the bench's scenarios. Those scenarios compare the outputs every cycle against a behavioural model, using both loopback and pseudo-random serial input.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic { SEL_TX = 1'b0, SEL_RX = 1'b1 } reg_sel_e;

  // number of sck half-periods in one byte
  function automatic int unsigned halves_per_byte(input int unsigned dw);
    return 2 * dw;
  endfunction
endpackage

// File: rtl/ssx_divider.sv
module ssx_divider #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half_div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == half_div);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int DW = 8,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] load_data,
  input  logic          sdi,
  output logic          busy,
  output logic          sck,
  output logic          sdo,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam logic [HW-1:0] LAST = HW'(ssx_pkg::halves_per_byte(DW) - 1);

  logic [DW-1:0] sh;
  logic          rbit;
  logic [HW-1:0] half;

  assign done    = tick && (half == LAST);
  assign rx_byte = {sh[DW-2:0], rbit};
  assign sdo     = busy ? sh[DW-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      rbit <= 1'b1;
      half <= '0;
      busy <= 1'b0;
      sck  <= 1'b1;
    end else if (start) begin
      sh   <= load_data;
      half <= '0;
      busy <= 1'b1;
      sck  <= 1'b0;
    end else if (tick) begin
      if (!half[0]) begin
        sck  <= 1'b1;
        rbit <= sdi;
        half <= half + 1'b1;
      end else if (half != LAST) begin
        sck  <= 1'b0;
        sh   <= {sh[DW-2:0], rbit};
        half <= half + 1'b1;
      end else begin
        busy <= 1'b0;
        sck  <= 1'b1;
        half <= '0;
      end
    end
  end
endmodule

// File: rtl/ssx_regs.sv
module ssx_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          lsb_first,
  input  logic          load,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] tx_buf,
  output logic [DW-1:0] rx_buf,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          overrun,
  output logic          tx_end
);
  import ssx_pkg::*;

  logic [DW-1:0] w_rev, r_rev;
  logic          tx_wr, rx_take, ovr_hit;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      w_rev[i] = wdata[DW-1-i];
      r_rev[i] = rx_byte[DW-1-i];
    end
  end

  assign tx_wr   = wr_en && (addr == SEL_TX);
  assign rx_take = done && !overrun && !rx_full;
  assign ovr_hit = done && !overrun && rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf   <= '1;
      rx_buf   <= '1;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      tx_end   <= 1'b1;
    end else begin
      if (tx_wr) begin
        tx_buf   <= lsb_first ? w_rev : wdata;
        tx_empty <= 1'b0;
      end else if (load) begin
        tx_empty <= 1'b1;
      end

      if (rx_take) begin
        rx_buf  <= lsb_first ? r_rev : rx_byte;
        rx_full <= 1'b1;
      end else if (rd_en && addr == SEL_RX) begin
        rx_full <= 1'b0;
      end

      if (ovr_hit)                         overrun <= 1'b1;
      else if (wr_en && addr == SEL_RX)    overrun <= 1'b0;

      if (load)      tx_end <= 1'b0;
      else if (done) tx_end <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            lsb_first,
  input  logic [DIVW-1:0] half_div,
  output logic            sck,
  output logic            sdo,
  input  logic            sdi,
  output logic            tx_empty,
  output logic            rx_full,
  output logic            overrun,
  output logic            tx_end
);
  import ssx_pkg::*;
  localparam int HW = $clog2(halves_per_byte(DW));

  logic          busy, tick, done, load;
  logic [DW-1:0] tx_buf, rx_buf, rx_byte;

  // named event: a byte enters the shifter
  assign load  = (!busy || done) && !tx_empty;
  assign rdata = (addr == SEL_RX) ? rx_buf : tx_buf;

  ssx_divider #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(half_div), .tick(tick)
  );

  ssx_shifter #(.DW(DW), .HW(HW)) u_shf (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(load), .load_data(tx_buf),
    .sdi(sdi), .busy(busy), .sck(sck), .sdo(sdo), .done(done), .rx_byte(rx_byte)
  );

  ssx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .lsb_first(lsb_first), .load(load), .done(done),
    .rx_byte(rx_byte), .tx_buf(tx_buf), .rx_buf(rx_buf), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .tx_end(tx_end)
  );
endmodule

// File: rtl/ssx_chk.sv
module ssx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          load,
  input logic          done,
  input logic          busy,
  input logic          sck,
  input logic          sdo,
  input logic          wr_en,
  input logic          addr,
  input logic [DW-1:0] rx_buf,
  input logic          rx_full,
  input logic          overrun,
  input logic          tx_empty,
  input logic          tx_end
);
  // R4
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(sck));
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck && sdo));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !tx_end && !sck));
  // R6
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rx_full && !overrun) |=> rx_full);
  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (rx_full || overrun)) |=> ($stable(rx_buf) && overrun));
  // R7
  rx_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !done) |=> $stable(rx_buf));
  // R8
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tx_empty) |=> tx_end);
endmodule

bind sync_serial_xcvr ssx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .done(done),
  .busy(busy), .sck(sck), .sdo(sdo), .wr_en(wr_en), .addr(addr),
  .rx_buf(rx_buf), .rx_full(rx_full), .overrun(overrun),
  .tx_empty(tx_empty), .tx_end(tx_end)
);

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, lsb_first = 1'b0;
  logic [7:0] wdata = 8'h00, half_div = 8'd1;
  logic [7:0] rdata;
  logic       sck, sdo, sdi, tx_empty, rx_full, overrun, tx_end;
  logic       loop = 1'b1, rnd_bit = 1'b0;
  int         checks = 0, errors = 0;
  bit         finished = 0;

  always #5 clk = ~clk;
  assign sdi = loop ? sdo : rnd_bit;

  sync_serial_xcvr uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lsb_first(lsb_first), .half_div(half_div),
    .sck(sck), .sdo(sdo), .sdi(sdi), .tx_empty(tx_empty), .rx_full(rx_full),
    .overrun(overrun), .tx_end(tx_end)
  );

  function automatic logic [7:0] flip(input logic [7:0] b);
    return {<<{b}};
  endfunction

  // behavioural reference model
  logic [7:0] m_tx, m_rx, m_out, m_in;
  bit         m_txe, m_rxf, m_ovr, m_tend, m_busy;
  int         m_wait, m_half;

  function automatic logic exp_sdo();
    return m_busy ? m_out[7 - (m_half / 2)] : 1'b1;
  endfunction
  function automatic logic exp_sck();
    return m_busy ? logic'(m_half % 2) : 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 8'hFF; m_rx = 8'hFF; m_out = 8'hFF; m_in = 8'h00;
      m_txe = 1; m_rxf = 0; m_ovr = 0; m_tend = 1; m_busy = 0;
      m_wait = 0; m_half = 0;
    end else begin
      logic s_in;
      bit   tk, fin, ld, take, lost;
      s_in = loop ? exp_sdo() : rnd_bit;
      tk   = m_busy && (m_wait == int'(half_div));
      fin  = tk && (m_half == 15);
      ld   = (!m_busy || fin) && !m_txe;
      take = fin && !m_ovr && !m_rxf;
      lost = fin && !m_ovr && m_rxf;
      if (tk && (m_half % 2 == 0)) m_in = {m_in[6:0], s_in};
      if (take) m_rx = lsb_first ? flip(m_in) : m_in;
      if (take) m_rxf = 1; else if (rd_en && addr) m_rxf = 0;
      if (lost) m_ovr = 1; else if (wr_en && addr) m_ovr = 0;
      if (ld) m_tend = 0; else if (fin) m_tend = 1;
      if (ld) begin
        m_out = m_tx; m_busy = 1; m_half = 0; m_wait = 0;
      end else if (tk) begin
        m_wait = 0;
        if (m_half == 15) begin m_busy = 0; m_half = 0; end
        else m_half++;
      end else if (m_busy) m_wait++;
      if (wr_en && !addr) begin
        m_tx = lsb_first ? flip(wdata) : wdata; m_txe = 0;
      end else if (ld) m_txe = 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 sck", 8'(sck), 8'(exp_sck()));
      chk("R4 sdo", 8'(sdo), 8'(exp_sdo()));
      chk("R2 tx_empty", 8'(tx_empty), 8'(m_txe));
      chk("R6 rx_full", 8'(rx_full), 8'(m_rxf));
      chk("R7 overrun", 8'(overrun), 8'(m_ovr));
      chk("R8 tx_end", 8'(tx_end), 8'(m_tend));
      chk("R5 rdata", rdata, addr ? m_rx : m_tx);
    end
  end

  always @(negedge clk) rnd_bit <= 1'($urandom);

  task automatic put(input logic a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 0; addr = 0;
  endtask

  task automatic put2(input logic [7:0] d0, input logic [7:0] d1);
    @(posedge clk); #2;
    wr_en = 1; addr = 0; wdata = d0;
    @(posedge clk); #2;
    wdata = d1;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic peek(input logic a, input bit take, output logic [7:0] v);
    @(posedge clk); #2;
    addr = a; rd_en = take;
    @(negedge clk);
    v = rdata;
    @(posedge clk); #2;
    rd_en = 0; addr = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    do begin
      @(negedge clk);
      if (!tx_end) n++;
    end while (!(tx_end && n > 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx reg", rdata, 8'hFF);
    chk("R1 flags", {4'h0, tx_empty, rx_full, overrun, tx_end}, 8'b0000_1001);
    chk("R1 lines", {6'h0, sck, sdo}, 8'h03);
    peek(1, 0, v); chk("R1 rx reg", v, 8'hFF);

    // R5/R6 MSB-first loopback, R4 single byte length
    half_div = 8'd1; lsb_first = 0;
    put(0, 8'hA5);
    busy_len(n); chk("R4 byte length", 8'(n), 8'd32);
    chk("R8 tx_end after byte", 8'(tx_end), 8'd1);
    peek(1, 1, v); chk("R6 rx byte msb", v, 8'hA5);
    @(negedge clk); chk("R6 rx_full cleared", 8'(rx_full), 8'd0);

    // R5 LSB-first: reversed storage and read-back, loopback restores value
    lsb_first = 1; half_div = 8'd0;
    put(0, 8'h01);
    peek(0, 0, v); chk("R5 reversed tx readback", v, 8'h80);
    busy_len(n);
    peek(1, 1, v); chk("R5 rx byte lsb", v, 8'h01);
    put(0, 8'h0E);
    busy_len(n);
    peek(1, 1, v); chk("R5 rx byte lsb 2", v, 8'h0E);

    // R3 gap-free burst, then R7 overrun
    lsb_first = 0; half_div = 8'd2;
    put2(8'h3C, 8'hC3);
    busy_len(n); chk("R3 burst length", 8'(n), 8'd96);
    chk("R7 overrun set", 8'(overrun), 8'd1);
    peek(1, 0, v); chk("R7 rx keeps first", v, 8'h3C);
    put(0, 8'h77);
    busy_len(n);
    peek(1, 0, v); chk("R7 discard while overrun", v, 8'h3C);
    put(1, 8'h00);
    @(negedge clk); chk("R7 overrun cleared", 8'(overrun), 8'd0);
    peek(1, 1, v); chk("R7 rx read-only", v, 8'h3C);

    // R4/R6 pseudo-random input under the per-cycle model
    loop = 0;
    for (int k = 0; k < 12; k++) begin
      half_div = 8'(k % 3);
      lsb_first = k[0];
      put(0, 8'(k * 37 + 5));
      busy_len(n);
      chk("R4 byte length rnd", 8'(n), 8'(16 * (k % 3 + 1)));
      if (k % 4 != 3) peek(1, 1, v);
      else put(1, 8'h00);
    end
    repeat (5) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule